// File: doc/BRIEF.md
# Serial Command Decoder with Register Readback

This block is the digital front end of a four-channel converter. It is a serial slave with four wires: a serial clock, an active-low select, a data input and a data output. A host selects it and sends a frame of 13 bits. The frame holds a start bit, a 2-bit command, a 2-bit address and 8 data bits. The block decodes the frame and acts on one of four 8-bit working registers. Each register drives the code of one converter channel.

The four commands are handled as follows.
- A write shifts in a new code.
- A read shifts the addressed code back out on the data output.
- A store-enable command is passed on as a one-clock strobe, with its address, to a separate nonvolatile controller.
- A recall command is passed on to the same controller in the same way.
While that controller reports busy, start bits are ignored, so no new frame can begin.

The block runs directly on the serial clock. A high select acts as an asynchronous reset of the frame logic. A separate active-low power-on reset clears the working registers.

Top module: `dacreg_serial`

## Requirements
- R1: While rstN is low, all four working registers read zero. Register k appears on dacCodes[8k+7:8k].
- R2: While csN is low and the block is idle, rising clock edges that sample sdi=0 are ignored. The first 1 that is sampled is the start bit of a frame.
- R3: After the start bit come the command bits C1,C0 and the address bits A1,A0. Command 01 (write) then shifts in 8 data bits, MSB first. The addressed register takes the new value on the rising edge of the 8th data bit. The other registers do not change.
- R4: Command 10 (read) drives the addressed register on sdo, D7 first. Each bit changes on a falling clock edge, starting with the falling edge that follows the A0 rising edge. sdoEn is high for exactly 8 bit periods.
- R5: sdoEn is low whenever no read data window is active. This includes the time before and after a read, and during write, store-enable and recall frames.
- R6: A read frame leaves all four registers unchanged.
- R7: After the 8th data clock, the frame logic is idle again. The next access needs a new start bit and a full frame, which may follow without releasing csN.
- R8: Raising csN aborts a partial frame. The register it was writing keeps its old value, and the next frame after csN falls decodes normally.
- R9: Command 00 (store enable) raises storeEnStb for one clock period, starting at the A0 rising edge, with nvAddr equal to the address. Its data bits do not change any register.
- R10: Command 11 (recall) raises recallStb for one clock period, starting at the A0 rising edge, with nvAddr equal to the address. storeEnStb and recallStb are never high together.
- R11: While nvBusy is high, a start bit is ignored. A whole frame sent during busy changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; input sampled on rising edge, output changes on falling edge |
| csN | input | 1 | Active-low select; high resets the frame logic asynchronously |
| rstN | input | 1 | Active-low power-on reset of the working registers |
| sdi | input | 1 | Serial data in |
| nvBusy | input | 1 | Nonvolatile controller busy; blocks new frames |
| sdo | output | 1 | Serial data out, meaningful while sdoEn is high |
| sdoEn | output | 1 | Output driver enable; low means high impedance |
| storeEnStb | output | 1 | One-clock store-enable strobe |
| recallStb | output | 1 | One-clock recall strobe |
| nvAddr | output | 2 | Address that goes with the strobes |
| dacCodes | output | 32 | Four packed 8-bit converter codes |

## Verification
A slipped header or bit counter shows up first at the data output. A read then starts one falling edge early or late, or loses or gains a bit, so the read window catches a count error within the same frame. A wrong command decode shows up as a register that changes when it should not, or a strobe on the wrong clock. Both can be seen one clock after the A0 edge or one clock after the last data edge. A frame state that survives deselect, or that is not blocked by busy, shows up in the next frame as a corrupted write.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 4;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int CMD_W    = 2;
  localparam int HDR_W    = CMD_W + ADDR_W;
  localparam int HCNT_W   = $clog2(HDR_W);
  localparam int BIT_W    = $clog2(DATA_W);

  typedef enum logic [CMD_W-1:0] {
    CMD_STORE  = 2'b00,
    CMD_WRITE  = 2'b01,
    CMD_READ   = 2'b10,
    CMD_RECALL = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    logic              shiftEn;
    logic              writeLast;
    logic              readEn;
    logic [BIT_W-1:0]  bitIdx;
    logic [ADDR_W-1:0] addr;
  } ctrl_strb_t;
endpackage

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
(
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdi,
  input  logic              nvBusy,
  output ctrl_strb_t        strb,
  output logic              storeEnStb,
  output logic              recallStb,
  output logic [ADDR_W-1:0] nvAddr,
  output phase_e            phase
);
  logic [HDR_W-1:0]  hdr;
  logic [HCNT_W-1:0] hdrCnt;
  logic [BIT_W-1:0]  dataCnt;
  logic [HDR_W-1:0]  hdrNext;
  cmd_e              cmdNext;
  cmd_e              cmdCur;

  assign hdrNext = {hdr[HDR_W-2:0], sdi};
  assign cmdNext = cmd_e'(hdrNext[HDR_W-1 -: CMD_W]);
  assign cmdCur  = cmd_e'(hdr[HDR_W-1 -: CMD_W]);
  assign nvAddr  = hdr[ADDR_W-1:0];

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      phase      <= PH_IDLE;
      hdr        <= '0;
      hdrCnt     <= '0;
      dataCnt    <= '0;
      storeEnStb <= 1'b0;
      recallStb  <= 1'b0;
    end else begin
      storeEnStb <= 1'b0;
      recallStb  <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (sdi && !nvBusy) begin
            phase  <= PH_HDR;
            hdrCnt <= '0;
          end
        end
        PH_HDR: begin
          hdr    <= hdrNext;
          hdrCnt <= hdrCnt + 1'b1;
          if (hdrCnt == HCNT_W'(HDR_W-1)) begin
            phase      <= PH_DATA;
            dataCnt    <= '0;
            storeEnStb <= (cmdNext == CMD_STORE);
            recallStb  <= (cmdNext == CMD_RECALL);
          end
        end
        PH_DATA: begin
          dataCnt <= dataCnt + 1'b1;
          if (dataCnt == BIT_W'(DATA_W-1)) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shiftEn   = (phase == PH_DATA) && (cmdCur == CMD_WRITE);
    strb.writeLast = strb.shiftEn && (dataCnt == BIT_W'(DATA_W-1));
    strb.readEn    = (phase == PH_DATA) && (cmdCur == CMD_READ);
    strb.bitIdx    = dataCnt;
    strb.addr      = hdr[ADDR_W-1:0];
  end
endmodule

// File: rtl/dacreg_datapath.sv
module dacreg_datapath
  import dacreg_pkg::*;
(
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       rstN,
  input  logic                       sdi,
  input  ctrl_strb_t                 strb,
  output logic                       sdo,
  output logic                       sdoEn,
  output logic [NUM_REGS*DATA_W-1:0] dacCodes
);
  logic [DATA_W-1:0] shiftIn;
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) shiftIn <= '0;
    else if (strb.shiftEn) shiftIn <= {shiftIn[DATA_W-2:0], sdi};
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
    end else if (strb.writeLast) begin
      regs[strb.addr] <= {shiftIn[DATA_W-2:0], sdi};
    end
  end

  always_ff @(negedge sclk or posedge csN) begin
    if (csN) begin
      sdoEn <= 1'b0;
      sdo   <= 1'b0;
    end else begin
      sdoEn <= strb.readEn;
      sdo   <= strb.readEn ? regs[strb.addr][BIT_W'(DATA_W-1) - strb.bitIdx] : 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign dacCodes[g*DATA_W +: DATA_W] = regs[g];
  end
endmodule

// File: rtl/dacreg_serial.sv
module dacreg_serial
  import dacreg_pkg::*;
(
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       rstN,
  input  logic                       sdi,
  input  logic                       nvBusy,
  output logic                       sdo,
  output logic                       sdoEn,
  output logic                       storeEnStb,
  output logic                       recallStb,
  output logic [ADDR_W-1:0]          nvAddr,
  output logic [NUM_REGS*DATA_W-1:0] dacCodes
);
  ctrl_strb_t strb;
  phase_e     phase;

  dacreg_ctrl u_ctrl (
    .sclk(sclk), .csN(csN), .sdi(sdi), .nvBusy(nvBusy), .strb(strb),
    .storeEnStb(storeEnStb), .recallStb(recallStb), .nvAddr(nvAddr), .phase(phase)
  );

  dacreg_datapath u_dp (
    .sclk(sclk), .csN(csN), .rstN(rstN), .sdi(sdi), .strb(strb),
    .sdo(sdo), .sdoEn(sdoEn), .dacCodes(dacCodes)
  );
endmodule

// File: rtl/dacreg_checker.sv
module dacreg_checker
  import dacreg_pkg::*;
(
  input logic                       sclk,
  input logic                       csN,
  input logic                       rstN,
  input logic                       nvBusy,
  input logic                       sdoEn,
  input logic                       storeEnStb,
  input logic                       recallStb,
  input logic [NUM_REGS*DATA_W-1:0] dacCodes,
  input ctrl_strb_t                 strb,
  input phase_e                     phase
);
  p_sdoen_window_r5: assert property (@(posedge sclk) disable iff (csN)
    sdoEn |-> strb.readEn);

  p_read_keeps_r6: assert property (@(posedge sclk) disable iff (csN || !rstN)
    strb.readEn |=> $stable(dacCodes));

  p_strobe_excl_r10: assert property (@(posedge sclk) disable iff (csN)
    !(storeEnStb && recallStb));

  p_recall_pulse_r10: assert property (@(posedge sclk) disable iff (csN)
    recallStb |=> !recallStb);

  p_store_pulse_r9: assert property (@(posedge sclk) disable iff (csN)
    storeEnStb |=> !storeEnStb);

  p_busy_block_r11: assert property (@(posedge sclk) disable iff (csN)
    (phase == PH_IDLE && nvBusy) |=> (phase == PH_IDLE));
endmodule

bind dacreg_serial dacreg_checker u_chk (
  .sclk(sclk), .csN(csN), .rstN(rstN), .nvBusy(nvBusy), .sdoEn(sdoEn),
  .storeEnStb(storeEnStb), .recallStb(recallStb), .dacCodes(dacCodes),
  .strb(strb), .phase(phase)
);

// File: tb/dacreg_serial_tb.sv
`timescale 1ns/1ps
module dacreg_serial_tb;
  logic sclk = 1'b0;
  logic csN = 1'b1, rstN = 1'b0, sdi = 1'b0, nvBusy = 1'b0;
  logic sdo, sdoEn, storeEnStb, recallStb;
  logic [1:0]  nvAddr;
  logic [31:0] dacCodes;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] model = '0;

  always #10 sclk = ~sclk;

  dacreg_serial u_dut (
    .sclk(sclk), .csN(csN), .rstN(rstN), .sdi(sdi), .nvBusy(nvBusy),
    .sdo(sdo), .sdoEn(sdoEn), .storeEnStb(storeEnStb), .recallStb(recallStb),
    .nvAddr(nvAddr), .dacCodes(dacCodes)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    @(negedge sclk); #2; sdi = b;
  endtask

  task automatic selectOn();
    @(negedge sclk); #2; csN = 1'b0;
  endtask

  task automatic selectOff();
    @(negedge sclk); #2; csN = 1'b1; sdi = 1'b0;
  endtask

  task automatic header(input logic [1:0] cmd, input logic [1:0] addr);
    bitOut(1'b1); bitOut(cmd[1]); bitOut(cmd[0]); bitOut(addr[1]); bitOut(addr[0]);
  endtask

  task automatic writeFrame(input logic [1:0] addr, input logic [7:0] val, input int lead);
    for (int i = 0; i < lead; i++) bitOut(1'b0);
    header(2'b01, addr);
    for (int i = 7; i >= 0; i--) bitOut(val[i]);
    bitOut(1'b0);
    model[addr*8 +: 8] = val;
  endtask

  task automatic t_reset();
    #35; check("R1 reset zero", dacCodes, 32'h0);
    check("R5 idle sdoEn", {31'h0, sdoEn}, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic t_write();
    selectOn();
    writeFrame(2'd2, 8'hA5, 3);
    check("R3 R2 write after idle zeros", dacCodes, model);
    writeFrame(2'd0, 8'h3C, 0);
    check("R7 back-to-back write", dacCodes, model);
    writeFrame(2'd3, 8'h81, 1);
    writeFrame(2'd1, 8'h7E, 2);
    check("R3 all addresses", dacCodes, model);
    selectOff();
  endtask

  task automatic t_read(input logic [1:0] addr);
    logic [7:0] exp;
    exp = model[addr*8 +: 8];
    selectOn();
    bitOut(1'b0);
    check("R5 before read", {31'h0, sdoEn}, 32'h0);
    header(2'b10, addr);
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b0);
      check("R4 read en", {31'h0, sdoEn}, 32'h1);
      check("R4 read bit", {31'h0, sdo}, {31'h0, exp[i]});
    end
    bitOut(1'b0);
    check("R4 read window end", {31'h0, sdoEn}, 32'h0);
    check("R6 read no change", dacCodes, model);
    selectOff();
  endtask

  task automatic t_abort();
    selectOn();
    header(2'b01, 2'd1);
    for (int i = 0; i < 5; i++) bitOut(1'b1);
    selectOff();
    check("R8 aborted write", dacCodes, model);
    selectOn();
    writeFrame(2'd1, 8'h12, 0);
    check("R8 frame after abort", dacCodes, model);
    selectOff();
  endtask

  task automatic t_strobe(input logic [1:0] cmd, input logic [1:0] addr);
    selectOn();
    header(cmd, addr);
    bitOut(1'b1);
    check("R9 R10 store strobe", {31'h0, storeEnStb}, {31'h0, cmd == 2'b00});
    check("R10 recall strobe", {31'h0, recallStb}, {31'h0, cmd == 2'b11});
    check("R9 R10 nvAddr", {30'h0, nvAddr}, {30'h0, addr});
    check("R5 no read en", {31'h0, sdoEn}, 32'h0);
    bitOut(1'b1);
    check("R9 R10 strobe width", {30'h0, storeEnStb, recallStb}, 32'h0);
    for (int i = 0; i < 7; i++) bitOut(1'b1);
    bitOut(1'b0);
    check("R9 data bits ignored", dacCodes, model);
    selectOff();
  endtask

  task automatic t_busy();
    int seen = 0;
    nvBusy = 1'b1;
    selectOn();
    header(2'b01, 2'd3);
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'(i % 2));
      if (storeEnStb || recallStb) seen++;
    end
    bitOut(1'b0);
    check("R11 busy blocks write", dacCodes, model);
    check("R11 busy no strobe", seen, 0);
    selectOff();
    nvBusy = 1'b0;
  endtask

  initial begin
    t_reset();
    t_write();
    t_read(2'd2);
    t_read(2'd3);
    t_abort();
    t_strobe(2'b00, 2'd2);
    t_strobe(2'b11, 2'd1);
    t_busy();
    t_read(2'd1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule